// File: doc/BRIEF.md
# Product-Term Macrocell

This block is one cell of a sum-of-products logic array. It builds five product terms from a bus of array inputs. The array inputs are the global input lines plus the inverted-term lines that other cells share. A per-term selection matrix chooses which local terms, and which terms borrowed from neighbouring cells, are ORed into the sum. The sum goes to the output either directly or through a storage element. That storage element is configured as a D or T flip-flop and is clocked either by the dedicated clock or by the first product term.

The cell can also give terms to other cells. Each local term can be passed, gated, onto a parallel-expander output. The bottom term is always offered in inverted form as a shared expander line. All behaviour comes from a configuration word. The word is shifted in serially, most significant bit first, while a load strobe is held high. The flip-flop state is always presented on a feedback output, whichever output mode is selected.

Top module: `pt_macrocell`

## Requirements
- R1: Array input vector x = {shr_in, gin}. Term k (0..4) is 1 exactly when every x bit selected true is 1 and every x bit selected complemented is 0. A term with no selections is 1. A term that selects one bit both true and complemented is 0.
- R2: The sum is the OR of (pt[k] AND term-enable[k]) over k, ORed with (pexp_in[k] AND borrow-enable[k]). A disabled term or a disabled borrowed line adds 0.
- R3: shr_out is the inverse of term 4.
- R4: pexp_out[k] equals term k AND lend[k]. This does not depend on the term-enable bits.
- R5: With registered-mode bit 0, mc_out equals the sum in the same cycle.
- R6: With registered-mode bit 1 and the D kind selected (toggle bit 0), the flip-flop takes the sum on each update edge. mc_out then shows the flip-flop. fb_out shows the flip-flop in every mode.
- R7: With toggle bit 1, the flip-flop inverts on each update edge where the sum is 1, and holds otherwise.
- R8: With clock-select bit 0, every clk rising edge is an update edge. With clock-select bit 1, only a clk edge where term 0 is 1 and was 0 at the previous edge is an update edge.
- R9: While cfg_load is 1, each clk edge shifts cfg_din into bit 0 of the configuration word, so the first bit sent ends at the top. Bit layout: 0 registered-mode, 1 toggle, 2 clock-select, 7:3 term-enable, 12:8 borrow-enable, 17:13 lend. Term k's true selections start at 18+20k, and its complemented selections start 10 bits above that (default widths). During loading, all outputs are 0 and the flip-flop is cleared.
- R10: A clk edge with rst_n low clears the flip-flop and the configuration word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| gin | input | N_IN | Global input bus |
| shr_in | input | N_SHR | Shared-expander lines from other cells |
| pexp_in | input | 5 | Borrowed product terms |
| pexp_out | output | 5 | Lent product terms |
| shr_out | output | 1 | Inverted bottom term |
| mc_out | output | 1 | Macrocell output |
| fb_out | output | 1 | Flip-flop feedback |

## Verification
The assertions assume that cfg_load, cfg_din and every data input hold known values after reset. They also assume that the product-term clock is sampled by clk like any other input, never used as a real clock. The bench changes every input on falling edges only, so each rising edge sees settled values. The bench draws random configurations with sparse literal selections, so that terms are often true and the toggle and product-term clock paths are exercised.

// File: rtl/mc_pkg.sv
// Shared constants for the product-term macrocell: term count and the
// bit offsets of the fixed fields in the configuration word.
package mc_pkg;
    localparam int NUM_PT    = 5;
    localparam int OFS_REG   = 0;
    localparam int OFS_TGL   = 1;
    localparam int OFS_CKS   = 2;
    localparam int OFS_PTEN  = 3;
    localparam int OFS_EXPEN = OFS_PTEN + NUM_PT;
    localparam int OFS_LEND  = OFS_EXPEN + NUM_PT;
    localparam int OFS_LIT   = OFS_LEND + NUM_PT;

    typedef enum logic {FF_D = 1'b0, FF_T = 1'b1} ff_kind_e;
endpackage

// File: rtl/mc_cfg_chain.sv
// Serial configuration register. Shifts one bit in at bit 0 per clock
// while load is high. Assumes the caller sends the top bit first.
module mc_cfg_chain #(
    parameter int W = 118
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         din,
    output logic [W-1:0] cfg
);
    // shift register: clear on reset, shift while loading
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg <= '0;
        else if (load) cfg <= {cfg[W-2:0], din};
    end

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cfg[0] == $past(din)));                              // R9
endmodule

// File: rtl/mc_and_array.sv
// Programmable AND plane: each term is the AND of the selected true and
// complemented array inputs. A term with nothing selected is 1.
module mc_and_array
    import mc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0]        x,
    input  logic [NUM_PT*AW-1:0] lit_t,
    input  logic [NUM_PT*AW-1:0] lit_c,
    output logic [NUM_PT-1:0]    pt
);
    for (genvar k = 0; k < NUM_PT; k++) begin : g_term
        // one product term: every selected literal must hold
        always_comb pt[k] = &((~lit_t[k*AW +: AW] | x) & (~lit_c[k*AW +: AW] | ~x));
    end
endmodule

// File: rtl/mc_sum_sel.sv
// Selection matrix and OR gate: gathers the enabled local terms and the
// enabled borrowed terms into one sum bit.
module mc_sum_sel
    import mc_pkg::*;
(
    input  logic [NUM_PT-1:0] pt,
    input  logic [NUM_PT-1:0] pt_en,
    input  logic [NUM_PT-1:0] pexp_in,
    input  logic [NUM_PT-1:0] exp_en,
    output logic              sum
);
    // OR of the chosen local and borrowed terms
    always_comb sum = |(pt & pt_en) | |(pexp_in & exp_en);
endmodule

// File: rtl/mc_flop.sv
// Configurable storage element. D or T behaviour. The update edge is
// every clk edge, or a clk edge where the term clock has just risen.
// The term clock is sampled as data and is never used as a real clock.
module mc_flop
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     d,
    input  ff_kind_e kind,
    input  logic     clk_sel,
    input  logic     ptclk,
    output logic     q
);
    logic ptclk_q;
    logic upd;

    // update qualifier from the selected clock source
    always_comb upd = clk_sel ? (ptclk & ~ptclk_q) : 1'b1;

    // previous value of the term clock, for rise detection
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ptclk_q <= 1'b0;
        else               ptclk_q <= ptclk;
    end

    // state: clear on reset or load, else D or T update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= 1'b0;
        else if (upd)      q <= (kind == FF_T) ? (q ^ d) : d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0));                                       // R10
    AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && kind == FF_D && !clr) |=> (q == $past(d)));            // R6
    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && kind == FF_T && !clr) |=> (q == ($past(q) ^ $past(d)))); // R7
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(q));                                // R8
endmodule

// File: rtl/pt_macrocell.sv
// Product-term macrocell top. Decodes the configuration word, forms the
// five terms, selects them into the sum, and drives the output either
// directly or through the flip-flop. All outputs stay 0 while loading.
module pt_macrocell
    import mc_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_SHR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_din,
    input  logic [N_IN-1:0]   gin,
    input  logic [N_SHR-1:0]  shr_in,
    input  logic [NUM_PT-1:0] pexp_in,
    output logic [NUM_PT-1:0] pexp_out,
    output logic              shr_out,
    output logic              mc_out,
    output logic              fb_out
);
    localparam int AW    = N_IN + N_SHR;
    localparam int CFG_W = OFS_LIT + 2 * NUM_PT * AW;

    logic [CFG_W-1:0]     cfg;
    logic [NUM_PT*AW-1:0] lit_t;
    logic [NUM_PT*AW-1:0] lit_c;
    logic [NUM_PT-1:0]    pt;
    logic [NUM_PT-1:0]    pt_en, exp_en, lend;
    logic [AW-1:0]        x;
    logic                 sum, q, reg_mode, clk_sel;
    ff_kind_e             kind;

    mc_cfg_chain #(.W(CFG_W)) i_chain (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .din(cfg_din), .cfg(cfg)
    );

    // field decode of the configuration word
    always_comb begin
        reg_mode = cfg[OFS_REG];
        kind     = ff_kind_e'(cfg[OFS_TGL]);
        clk_sel  = cfg[OFS_CKS];
        pt_en    = cfg[OFS_PTEN  +: NUM_PT];
        exp_en   = cfg[OFS_EXPEN +: NUM_PT];
        lend     = cfg[OFS_LEND  +: NUM_PT];
        x        = {shr_in, gin};
    end

    for (genvar k = 0; k < NUM_PT; k++) begin : g_lit
        assign lit_t[k*AW +: AW] = cfg[OFS_LIT + k*2*AW      +: AW];
        assign lit_c[k*AW +: AW] = cfg[OFS_LIT + k*2*AW + AW +: AW];
    end

    mc_and_array #(.AW(AW)) i_and (
        .x(x), .lit_t(lit_t), .lit_c(lit_c), .pt(pt)
    );

    mc_sum_sel i_sum (
        .pt(pt), .pt_en(pt_en), .pexp_in(pexp_in), .exp_en(exp_en), .sum(sum)
    );

    mc_flop i_ff (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load), .d(sum), .kind(kind),
        .clk_sel(clk_sel), .ptclk(pt[0]), .q(q)
    );

    // output stage, forced quiet during loading
    always_comb begin
        pexp_out = cfg_load ? '0 : (pt & lend);
        shr_out  = ~cfg_load & ~pt[NUM_PT-1];
        mc_out   = ~cfg_load & (reg_mode ? q : sum);
        fb_out   = ~cfg_load & q;
    end

    AST_BORROW_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !reg_mode && |(pexp_in & exp_en)) |-> mc_out);  // R2
endmodule

// File: tb/test_pt_macrocell.sv
module test_pt_macrocell;
    localparam int N_IN = 8, N_SHR = 2, AW = N_IN + N_SHR;
    localparam int CFG_W = 18 + 10 * AW;

    logic clk = 0, rst_n = 0, cfg_load = 0, cfg_din = 0;
    logic [N_IN-1:0] gin = '0;
    logic [N_SHR-1:0] shr_in = '0;
    logic [4:0] pexp_in = '0, pexp_out;
    logic shr_out, mc_out, fb_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bit b_reg, b_t, b_cks;
    bit [4:0] b_pten, b_expen, b_lend;
    bit [AW-1:0] b_lt[5], b_lc[5];
    bit e_q, e_prev;

    pt_macrocell #(.N_IN(N_IN), .N_SHR(N_SHR)) i_pt_macrocell (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
        .gin(gin), .shr_in(shr_in), .pexp_in(pexp_in), .pexp_out(pexp_out),
        .shr_out(shr_out), .mc_out(mc_out), .fb_out(fb_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit f_pt(int k, bit [AW-1:0] xv);
        bit r = 1;
        for (int j = 0; j < AW; j++) begin
            if (b_lt[k][j] && !xv[j]) r = 0;
            if (b_lc[k][j] &&  xv[j]) r = 0;
        end
        return r;
    endfunction

    function automatic bit f_sum(bit [AW-1:0] xv, bit [4:0] pe);
        bit r = 0;
        for (int k = 0; k < 5; k++) r |= (f_pt(k, xv) & b_pten[k]) | (pe[k] & b_expen[k]);
        return r;
    endfunction

    function automatic bit [CFG_W-1:0] f_pack();
        bit [CFG_W-1:0] v = '0;
        v[0] = b_reg; v[1] = b_t; v[2] = b_cks;
        v[7:3] = b_pten; v[12:8] = b_expen; v[17:13] = b_lend;
        for (int k = 0; k < 5; k++) begin
            v[18 + k*2*AW +: AW] = b_lt[k];
            v[18 + k*2*AW + AW +: AW] = b_lc[k];
        end
        return v;
    endfunction

    task automatic clear_cfg();
        b_reg = 0; b_t = 0; b_cks = 0; b_pten = 0; b_expen = 0; b_lend = 0;
        for (int k = 0; k < 5; k++) begin b_lt[k] = '0; b_lc[k] = '0; end
    endtask

    // shift the bench configuration in, top bit first; starts and ends at a falling edge
    task automatic load_cfg();
        bit [CFG_W-1:0] v = f_pack();
        cfg_load = 1;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            cfg_din = v[i];
            @(posedge clk); #1;
            if (i == CFG_W / 2) begin
                check("R9 load quiet mc_out", mc_out, 0);
                check("R9 load quiet fb_out", fb_out, 0);
                check("R9 load quiet pexp_out", pexp_out, 0);
            end
            @(negedge clk);
        end
        cfg_load = 0;
        e_q = 0; e_prev = 0;
    endtask

    // apply one input set and check outputs before and after the next edge
    task automatic step(input bit [N_IN-1:0] g, input bit [N_SHR-1:0] s, input bit [4:0] pe);
        bit [AW-1:0] xv;
        bit sm, p0, en;
        bit [4:0] lentv;
        string ftag;
        gin = g; shr_in = s; pexp_in = pe;
        xv = {s, g};
        sm = f_sum(xv, pe);
        p0 = f_pt(0, xv);
        for (int k = 0; k < 5; k++) lentv[k] = f_pt(k, xv) & b_lend[k];
        #1;
        if (!b_reg) check("R5/R2 comb output", mc_out, sm);
        check("R3 shared expander", shr_out, !f_pt(4, xv));
        check("R4 lent terms", pexp_out, lentv);
        @(posedge clk);
        en = !b_cks || (p0 && !e_prev);
        e_prev = p0;
        if (en) e_q = b_t ? (e_q ^ sm) : sm;
        #1;
        ftag = b_cks ? "R8 term clock" : (b_t ? "R7 toggle" : "R6 D capture");
        check(ftag, fb_out, e_q);
        if (b_reg) check(ftag, mc_out, e_q);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        clear_cfg();
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset mc_out", mc_out, 0);
        check("R10 reset fb_out", fb_out, 0);
        check("R10 reset pexp_out", pexp_out, 0);
        check("R10 reset shr_out", shr_out, 0);
        rst_n = 1;
        @(negedge clk);

        // R1: an empty term is 1, a term with contradicting literals is 0
        clear_cfg(); b_pten = 5'b00001; load_cfg();
        gin = 8'h5a; #1; check("R1 empty term true", mc_out, 1);
        @(negedge clk);
        clear_cfg(); b_pten = 5'b00010; b_lt[1][3] = 1; b_lc[1][3] = 1; load_cfg();
        gin = 8'h08; #1; check("R1 contradicting term false", mc_out, 0);
        gin = 8'h00; #1; check("R1 contradicting term false", mc_out, 0);
        @(negedge clk);
        // R1: shared-expander input used as a literal
        clear_cfg(); b_pten = 5'b00100; b_lt[2][N_IN] = 1; b_lc[2][0] = 1; load_cfg();
        step(8'h00, 2'b01, 5'h0);
        gin = 8'h01; shr_in = 2'b01; #1; check("R1 complemented literal", mc_out, 0);
        @(negedge clk);
        // R2: borrowed term only when enabled; disabled borrowed line adds 0
        clear_cfg(); b_expen = 5'b10000; load_cfg();
        pexp_in = 5'b01111; #1; check("R2 disabled borrow", mc_out, 0);
        pexp_in = 5'b10000; #1; check("R2 enabled borrow", mc_out, 1);
        @(negedge clk);
        // R4: lending independent of term enable
        clear_cfg(); b_lend = 5'b10101; load_cfg();
        step(8'hff, 2'b11, 5'h0);
        // R7: toggle with an always-true sum
        clear_cfg(); b_reg = 1; b_t = 1; b_pten = 5'b00001; load_cfg();
        repeat (4) step(8'h00, 2'b00, 5'h0);
        // R8: term clock on bit 0 of gin, D mode, sum from borrow line
        clear_cfg(); b_reg = 1; b_cks = 1; b_lt[0][0] = 1; b_expen = 5'b00001; load_cfg();
        step(8'h00, 2'b00, 5'h1);
        step(8'h01, 2'b00, 5'h1);
        step(8'h01, 2'b00, 5'h0);
        step(8'h00, 2'b00, 5'h0);
        step(8'h01, 2'b00, 5'h0);

        // constrained random configurations and inputs
        for (int r = 0; r < 30; r++) begin
            b_reg = $urandom % 2; b_t = $urandom % 2; b_cks = ($urandom % 3) == 0;
            b_pten = $urandom; b_expen = $urandom & $urandom; b_lend = $urandom;
            for (int k = 0; k < 5; k++)
                for (int j = 0; j < AW; j++) begin
                    int c = $urandom % 10;
                    b_lt[k][j] = (c == 0);
                    b_lc[k][j] = (c == 1);
                end
            load_cfg();
            for (int n = 0; n < 20; n++) step($urandom, $urandom, $urandom & $urandom);
        end

        // R10: reset mid-run clears flip-flop and configuration
        clear_cfg(); b_reg = 1; b_pten = 5'b00001; load_cfg();
        step(8'h00, 2'b00, 5'h0);
        check("R10 set before reset", fb_out, 1);
        rst_n = 0;
        @(posedge clk); #1;
        check("R10 reset clears fb_out", fb_out, 0);
        check("R10 reset clears mc_out", mc_out, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule